// File: doc/BRIEF.md
# Bridge ADC Host Reader

This block sits on the host side of a two-wire link to a 24-bit delta-sigma bridge-sensor converter. The converter shares one line for both "conversion ready" and "serial data". The reader watches that line, and once the line drops low it drives a serial clock to shift the signed 24-bit result out, most significant bit first. It then hands the word to the host logic as a single-cycle valid strobe. An overrange flag accompanies the word.

Each transfer ends with one extra clock pulse. This pulse returns the shared line to its idle-high level, so the next poll is not confused by a stale data bit. The host can park the converter in its low-power standby state by holding a level request: while that request is held, the serial clock stays high. Releasing the request brings the clock low again, which wakes the converter. After the analog input has changed, for example after an external multiplexer switches, a flush pulse makes the reader throw away the next four results. Only the fifth result is delivered, because it is the first one fully settled. The high and low phases of the serial clock are set in system clocks. A watchdog reports a converter that never signals ready.

Top module: `bridge_adc_reader`

## Requirements
- R1: While `run_i` is high and `sdi_i` stays high, no serial clock pulse is produced. A transfer starts only in the cycle after `sdi_i` is seen low.
- R2: A transfer samples 24 bits, one in each serial clock high phase, in the last system clock of that phase. The first bit sampled is the most significant bit of `data_o`.
- R3: Every transfer produces exactly 25 rising edges on `sclk_o`: 24 for data and one extra that returns the line high. The extra pulse samples nothing.
- R4: While `standby_i` is high and no transfer is running, `sclk_o` is held high and no transfer starts, even if `sdi_i` is low. When `standby_i` falls, `sclk_o` returns low and normal polling resumes.
- R5: A `flush_i` pulse causes the next four completed transfers to be dropped, with no `valid_o`. The fifth is delivered. If a transfer is in progress when the flush arrives, it counts as one of the four.
- R6: `ovr_o` is 1 with a delivered word exactly when that word equals 24'h7FFFFF or 24'h800000, and 0 for every other code.
- R7: Each serial clock high phase lasts `hi_len_i` system clocks and each low phase inside a transfer lasts `lo_len_i` system clocks. A setting of 0 acts as 1.
- R8: While the reader is waiting for ready and `sdi_i` stays high, `timeout_o` pulses once every `wait_limit_i`+1 system clocks. A limit of 0 disables the timeout.
- R9: `valid_o` is a single-cycle pulse per delivered word. `busy_o` is high from the first serial clock rise of a transfer to its completion and low when idle or in standby.
- R10: With `rst` high at a clock edge, the next outputs are `sclk_o`=0, `valid_o`=0, `busy_o`=0 and `timeout_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi_i | input | 1 | Shared ready/data line from the converter (low = ready, then data) |
| run_i | input | 1 | Level: poll and read continuously while high |
| standby_i | input | 1 | Level: hold serial clock high to park the converter |
| flush_i | input | 1 | Pulse: discard the next four results |
| hi_len_i | input | 8 | Serial clock high phase length in system clocks |
| lo_len_i | input | 8 | Serial clock low phase length in system clocks |
| wait_limit_i | input | 16 | Ready-wait timeout limit, 0 disables |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | 24 | Last delivered two's complement result |
| ovr_o | output | 1 | Delivered result is at a full-scale code |
| valid_o | output | 1 | One-cycle strobe: `data_o`/`ovr_o` updated |
| busy_o | output | 1 | Transfer in progress |
| timeout_o | output | 1 | One-cycle pulse: ready not seen within the limit |

## Verification
A bit counter out of step with the converter shows up at the ports within one transfer. A counter off by one either way shifts every bit of `data_o` by one place, and it changes the count of serial clock rises away from 25. A stuck or mis-loaded drop counter shows within five transfers after a flush, as a strobe that arrives early or never arrives. A wrong phase counter shows in the first pulse as a high or low width that does not match the programmed lengths. A standby state left wrongly shows within a few clocks as a serial clock that falls while the request is held, or as a read that starts during standby.

// File: rtl/bar_pkg.sv
package bar_pkg;

    localparam int unsigned SAMPLE_W = 24;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HIGH,
        ST_LOW,
        ST_DONE,
        ST_STBY
    } rd_state_e;

    typedef struct packed {
        sample_t code;
        logic    ovr;
    } result_t;

    localparam sample_t POS_FULL = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t NEG_FULL = {1'b1, {(SAMPLE_W-1){1'b0}}};

    function automatic logic at_full_scale(sample_t c);
        return (c == POS_FULL) || (c == NEG_FULL);
    endfunction

    function automatic result_t make_result(sample_t c);
        result_t r;
        r.code = c;
        r.ovr  = at_full_scale(c);
        return r;
    endfunction

endpackage

// File: rtl/bar_phase_timer.sv
module bar_phase_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic [DIV_W-1:0] len_i,
    output logic             last_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] len_m1;

    // a zero length behaves like a length of one
    assign len_m1 = (len_i == '0) ? '0 : len_i - 1'b1;
    assign last_o = active_i && (cnt >= len_m1);

    always_ff @(posedge clk) begin
        if (rst || !active_i || last_o)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_PHASE_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (cnt == '0)) else $error("phase counter kept count"); // R7

endmodule

// File: rtl/bar_shift_in.sv
module bar_shift_in #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         take_i,
    input  logic         din_i,
    output logic [W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            word_o <= '0;
        else if (take_i)
            word_o <= {word_o[W-2:0], din_i};
    end
endmodule

// File: rtl/bar_result_stage.sv
module bar_result_stage
    import bar_pkg::*;
#(
    parameter int unsigned DROP_N = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    flush_i,
    input  logic    done_i,
    input  sample_t word_i,
    output sample_t data_o,
    output logic    ovr_o,
    output logic    valid_o
);
    localparam int unsigned DROP_W = (DROP_N < 1) ? 1 : $clog2(DROP_N + 1);
    localparam logic [DROP_W-1:0] DROP_LOAD = DROP_W'(DROP_N);

    logic [DROP_W-1:0] drop_cnt;
    result_t           res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_cnt <= '0;
        end else if (flush_i) begin
            drop_cnt <= DROP_LOAD;
        end else if (done_i && drop_cnt != '0) begin
            drop_cnt <= drop_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (done_i && drop_cnt == '0 && !flush_i) begin
                res_q   <= make_result(word_i);
                valid_o <= 1'b1;
            end
        end
    end

    assign data_o = res_q.code;
    assign ovr_o  = res_q.ovr;

    AST_DROP_BOUND: assert property (@(posedge clk) disable iff (rst)
        drop_cnt <= DROP_LOAD) else $error("drop counter overflow"); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R9
    AST_OVR_FULLSCALE: assert property (@(posedge clk) disable iff (rst)
        (valid_o && ovr_o) |-> (data_o == POS_FULL || data_o == NEG_FULL))
        else $error("overrange flag on in-range code"); // R6

endmodule

// File: rtl/bar_wait_watchdog.sv
module bar_wait_watchdog #(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            timeout_o
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || limit_i == '0) begin
            cnt       <= '0;
            timeout_o <= 1'b0;
        end else if (cnt >= limit_i) begin
            cnt       <= '0;
            timeout_o <= 1'b1;
        end else begin
            cnt       <= cnt + 1'b1;
            timeout_o <= 1'b0;
        end
    end

    AST_TIMEOUT_ARMED: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(arm_i)) else $error("timeout while not waiting"); // R8

endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader
    import bar_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned TO_W   = 16,
    parameter int unsigned DROP_N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sdi_i,
    input  logic                run_i,
    input  logic                standby_i,
    input  logic                flush_i,
    input  logic [DIV_W-1:0]    hi_len_i,
    input  logic [DIV_W-1:0]    lo_len_i,
    input  logic [TO_W-1:0]     wait_limit_i,
    output logic                sclk_o,
    output logic [SAMPLE_W-1:0] data_o,
    output logic                ovr_o,
    output logic                valid_o,
    output logic                busy_o,
    output logic                timeout_o
);
    localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] TAIL_PULSE = CNT_W'(SAMPLE_W);

    rd_state_e        state;
    logic [CNT_W-1:0] pulse_idx;
    logic             ph_active;
    logic             ph_last;
    logic [DIV_W-1:0] ph_len;
    logic             take_bit;
    sample_t          word;

    assign ph_active = (state == ST_HIGH) || (state == ST_LOW);
    assign ph_len    = (state == ST_HIGH) ? hi_len_i : lo_len_i;
    assign take_bit  = (state == ST_HIGH) && ph_last && (pulse_idx != TAIL_PULSE);
    assign busy_o    = ph_active || (state == ST_DONE);

    bar_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .active_i (ph_active),
        .len_i    (ph_len),
        .last_o   (ph_last)
    );

    bar_shift_in #(.W(SAMPLE_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (state == ST_WAIT),
        .take_i (take_bit),
        .din_i  (sdi_i),
        .word_o (word)
    );

    bar_result_stage #(.DROP_N(DROP_N)) u_result (
        .clk     (clk),
        .rst     (rst),
        .flush_i (flush_i),
        .done_i  (state == ST_DONE),
        .word_i  (word),
        .data_o  (data_o),
        .ovr_o   (ovr_o),
        .valid_o (valid_o)
    );

    bar_wait_watchdog #(.TO_W(TO_W)) u_watchdog (
        .clk       (clk),
        .rst       (rst),
        .arm_i     ((state == ST_WAIT) && sdi_i && !standby_i && run_i),
        .limit_i   (wait_limit_i),
        .timeout_o (timeout_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sclk_o    <= 1'b0;
            pulse_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (standby_i) begin
                        state  <= ST_STBY;
                        sclk_o <= 1'b1;
                    end else if (run_i) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (standby_i) begin
                        state  <= ST_STBY;
                        sclk_o <= 1'b1;
                    end else if (!run_i) begin
                        state <= ST_IDLE;
                    end else if (!sdi_i) begin
                        state     <= ST_HIGH;
                        sclk_o    <= 1'b1;
                        pulse_idx <= '0;
                    end
                end
                ST_HIGH: begin
                    if (ph_last) begin
                        state  <= ST_LOW;
                        sclk_o <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (ph_last) begin
                        if (pulse_idx == TAIL_PULSE) begin
                            state <= ST_DONE;
                        end else begin
                            pulse_idx <= pulse_idx + 1'b1;
                            state     <= ST_HIGH;
                            sclk_o    <= 1'b1;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                ST_STBY: begin
                    if (!standby_i) begin
                        state  <= ST_IDLE;
                        sclk_o <= 1'b0;
                    end
                end
                default: begin
                    state  <= ST_IDLE;
                    sclk_o <= 1'b0;
                end
            endcase
        end
    end

    AST_READ_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && $past(state) == ST_WAIT) |-> !$past(sdi_i))
        else $error("transfer started with line high"); // R1
    AST_STBY_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STBY) |-> sclk_o) else $error("clock low in standby"); // R4
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pulse_idx <= TAIL_PULSE) else $error("pulse index overflow"); // R3
    AST_NO_SAMPLE_ON_TAIL: assert property (@(posedge clk) disable iff (rst)
        take_bit |-> (sclk_o && pulse_idx < TAIL_PULSE)) else $error("bad sample point"); // R2

endmodule

// File: tb/bridge_adc_reader_tb.sv
module bridge_adc_reader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi;
    logic        run = 1'b0;
    logic        standby = 1'b0;
    logic        flush = 1'b0;
    logic [7:0]  hi_len = 8'd2;
    logic [7:0]  lo_len = 8'd3;
    logic [15:0] wait_limit = 16'd0;
    logic        sclk, ovr, valid, busy, tout;
    logic [23:0] data;

    int n_checks = 0;
    int n_fails  = 0;

    bridge_adc_reader dut_i (
        .clk(clk), .rst(rst), .sdi_i(sdi), .run_i(run), .standby_i(standby),
        .flush_i(flush), .hi_len_i(hi_len), .lo_len_i(lo_len),
        .wait_limit_i(wait_limit), .sclk_o(sclk), .data_o(data), .ovr_o(ovr),
        .valid_o(valid), .busy_o(busy), .timeout_o(tout)
    );

    always #4 clk = ~clk;

    // converter model: line low = ready, each sclk rise shifts next bit out
    int          pos = 0;
    int          base = 0;
    logic        present = 1'b0;
    logic [23:0] word_r = '0;

    always @(posedge sclk) pos <= pos + 1;

    always @* begin
        if (!present)
            sdi = 1'b1;
        else if (pos - base == 0)
            sdi = 1'b0;
        else if (pos - base <= 24)
            sdi = word_r[24 - (pos - base)];
        else
            sdi = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    logic [24:0] exp_q[$];

    always @(negedge clk) begin
        if (!rst && valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected valid word", data, 0);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                chk(data == e[24:1], "R2", "data word", data, e[24:1]);
                chk(ovr == e[0], "R6", "overrange flag", ovr, e[0]);
            end
        end
    end

    // sclk phase width measurement
    logic sclk_prev = 1'b0;
    int   run_len = 0;
    int   last_hi = 0;
    int   last_lo = 0;

    always @(negedge clk) begin
        if (sclk == sclk_prev) begin
            run_len++;
        end else begin
            if (sclk_prev) last_hi = run_len; else last_lo = run_len;
            run_len = 1;
        end
        sclk_prev = sclk;
    end

    function automatic logic is_fs(logic [23:0] w);
        return (w == 24'h7FFFFF) || (w == 24'h800000);
    endfunction

    task automatic convert(input logic [23:0] w, input bit deliver);
        int p0;
        wait (!busy);
        repeat (3) @(negedge clk);
        p0 = pos;
        base = pos;
        word_r = w;
        present = 1'b1;
        if (deliver) exp_q.push_back({w, is_fs(w)});
        @(posedge busy);
        wait (!busy);
        @(negedge clk);
        present = 1'b0;
        chk(pos - p0 == 25, "R3", "sclk rises per transfer", pos - p0, 25);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0 && valid == 1'b0 && busy == 1'b0 && tout == 1'b0,
            "R10", "reset outputs", {sclk, valid, busy, tout}, 0);
        rst = 1'b0;

        // R1: line high, no clocks
        run = 1'b1;
        begin
            int p0;
            p0 = pos;
            repeat (30) @(negedge clk);
            chk(pos == p0 && busy == 1'b0, "R1", "no sclk while line high", pos - p0, 0);
        end

        // R2/R6 basic words
        convert(24'hA5C3_0F, 1'b1);
        chk(last_hi == 2 && last_lo == 3, "R7", "phase widths 2/3", {last_hi, last_lo}, {32'd2, 32'd3});
        convert(24'h000001, 1'b1);
        convert(24'h7FFFFF, 1'b1);
        convert(24'h800000, 1'b1);
        convert(24'h7FFFFE, 1'b1);
        convert(24'hFFFFFF, 1'b1);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all words delivered", exp_q.size(), 0);

        // R7 other widths, zero acts as one
        hi_len = 8'd0; lo_len = 8'd0;
        convert(24'h123456, 1'b1);
        chk(last_hi == 1 && last_lo == 1, "R7", "zero width acts as one", {last_hi, last_lo}, {32'd1, 32'd1});
        hi_len = 8'd4; lo_len = 8'd1;
        convert(24'h654321, 1'b1);
        chk(last_hi == 4 && last_lo == 1, "R7", "phase widths 4/1", {last_hi, last_lo}, {32'd4, 32'd1});
        hi_len = 8'd2; lo_len = 8'd2;

        // R5: flush, four dropped, fifth delivered
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        convert(24'h111111, 1'b0);
        convert(24'h222222, 1'b0);
        convert(24'h333333, 1'b0);
        convert(24'h444444, 1'b0);
        chk(exp_q.size() == 0, "R5", "nothing pending after drops", exp_q.size(), 0);
        convert(24'h555555, 1'b1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "fifth word delivered", exp_q.size(), 0);

        // R4: standby holds clock high, no read while ready
        standby = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b1 && busy == 1'b0, "R4", "sclk high in standby", sclk, 1);
        base = pos; word_r = 24'h0ABCDE; present = 1'b1;
        exp_q.push_back({24'h0ABCDE, 1'b0});
        repeat (40) @(negedge clk);
        chk(sclk == 1'b1 && busy == 1'b0 && pos == base, "R4", "no read during standby", pos - base, 0);
        standby = 1'b0;
        repeat (2) @(negedge clk);
        chk(pos == base, "R4", "sclk low after release", pos - base, 0);
        wait (!busy && pos - base == 25);
        repeat (3) @(negedge clk);
        present = 1'b0;
        chk(exp_q.size() == 0, "R4", "read after wake", exp_q.size(), 0);

        // R8: timeout period limit+1
        wait_limit = 16'd10;
        begin
            int gap;
            int guard;
            guard = 0;
            while (!tout && guard < 200) begin @(negedge clk); guard++; end
            chk(tout == 1'b1, "R8", "first timeout", tout, 1);
            gap = 0;
            @(negedge clk); gap = 1;
            while (!tout && gap < 200) begin @(negedge clk); gap++; end
            chk(gap == 11, "R8", "timeout period", gap, 11);
        end
        wait_limit = 16'd0;
        begin
            int seen;
            seen = 0;
            repeat (60) begin @(negedge clk); if (tout) seen++; end
            chk(seen == 0, "R8", "limit zero disables", seen, 0);
        end

        // R9: valid is a single pulse
        begin
            int vcnt;
            vcnt = 0;
            exp_q.push_back({24'h13579B, 1'b0});
            base = pos; word_r = 24'h13579B; present = 1'b1;
            repeat (400) begin @(negedge clk); if (valid) vcnt++; end
            present = 1'b0;
            chk(vcnt == 1, "R9", "one valid per transfer", vcnt, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule